// File: doc/BRIEF.md
# Compact Sized Shift and Rotate Unit

This block is a purely combinational shifter for the short-form shift and rotate instructions. It takes a 64-bit operand, a shift count and a five-bit slice of the instruction word. From that slice it decodes an operation and an operand width. The operations are logical left, logical right, rotate left and arithmetic right. The widths are 8, 16, 32 and 64 bits.

Only the low bits of the operand that fall inside the selected width take part. The shift count is reduced modulo that width. The result at the selected width is sign-extended to fill all 64 output bits.

The short form has no arithmetic left shift; rotate left uses that encoding slot. The unit produces no flags of any kind, so the short shifts can never disturb condition codes. Fetching the count from a register and writing the result back belong to the surrounding datapath.

Top module: `cmp_shift_unit`

## Requirements
- R1: `code_i` carries instruction bits 13 down to 9. If `code_i[4]` is 0 the width is 64. Otherwise `code_i[1:0]` selects the width: 11 gives 8, 10 gives 16, and 00 or 01 give 32. `code_i[3:2]` selects the operation: 00 logical left, 01 logical right, 10 rotate left, 11 arithmetic right.
- R2: A logical left shift by k moves the width-W operand up by k places and fills the k low positions with zeros.
- R3: A logical right shift by k moves the width-W operand down by k places and fills the k top positions of the width with zeros.
- R4: An arithmetic right shift by k fills the k top positions of the width with copies of bit W-1 of the operand.
- R5: A rotate left by k places at output bit i the operand bit (i-k) mod W, so no bit is lost within the width.
- R6: Only the low log2(W) bits of `cnt_i` are used, so the effective count is `cnt_i` mod W.
- R7: Operand bits at positions W and above have no effect on `res_o`.
- R8: Bits W to 63 of `res_o` all equal bit W-1 of `res_o`.
- R9: An effective count of zero returns the width-W operand unchanged, sign-extended to 64 bits, for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| code_i | input | 5 | Instruction bits 13..9 selecting operation and width |
| opnd_i | input | 64 | Operand to be shifted |
| cnt_i | input | 6 | Shift count, used modulo the selected width |
| res_o | output | 64 | Shifted result, sign-extended from the selected width |

## Verification
Three effects can land in the same result. The fill at the top of a narrow width, the wrap of the count modulo that width, and the sign extension up to 64 bits all coincide on an arithmetic right shift of a negative byte or halfword with a count at or above the width. The sweep runs every code value against every count from 0 to 63, using operands whose narrow-width sign bits are set and whose upper bits are deliberately dirty. An independent bit-by-bit model in the bench computes the expected word. Separate probes compare results for clean and dirty upper bits, and check that the extended bits replicate the width's top bit.

// File: rtl/shu_pkg.sv
package shu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_LONG = 2'd3
   } shu_size_e;

   typedef enum logic [1:0] {
      OP_LSL = 2'd0,
      OP_LSR = 2'd1,
      OP_ROL = 2'd2,
      OP_ASR = 2'd3
   } shu_op_e;

   localparam int unsigned SHU_LANES = 4;
endpackage

// File: rtl/shu_decode.sv
module shu_decode
   import shu_pkg::*;
(
   input  logic [4:0] code_i,
   output shu_size_e  size_o,
   output shu_op_e    op_o
);
   always_comb begin
      op_o = shu_op_e'(code_i[3:2]);
      if (!code_i[4]) begin
         size_o = SZ_LONG;
      end else begin
         unique case (code_i[1:0])
            2'b11:   size_o = SZ_BYTE;
            2'b10:   size_o = SZ_HALF;
            default: size_o = SZ_WORD;
         endcase
      end
   end
endmodule

// File: rtl/shu_lane.sv
module shu_lane
   import shu_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned LC_W  = $clog2(LANE_W)
)(
   input  logic [LANE_W-1:0] x_i,
   input  logic [LC_W-1:0]   cnt_i,
   input  shu_op_e           op_i,
   output logic [DATA_W-1:0] res_o
);
   logic [LANE_W-1:0] y;
   logic [LC_W:0]     back;

   assign back = (LC_W+1)'(LANE_W) - {1'b0, cnt_i};

   always_comb begin
      unique case (op_i)
         OP_LSL:  y = x_i << cnt_i;
         OP_LSR:  y = x_i >> cnt_i;
         OP_ROL:  y = (x_i << cnt_i) | (x_i >> back);
         default: y = LANE_W'($signed(x_i) >>> cnt_i);
      endcase
   end

   generate
      if (LANE_W == DATA_W) begin : g_full
         assign res_o = y;
      end else begin : g_ext
         assign res_o = {{(DATA_W-LANE_W){y[LANE_W-1]}}, y};
      end
   endgenerate
endmodule

// File: rtl/cmp_shift_unit.sv
module cmp_shift_unit
   import shu_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned CNT_W = $clog2(DATA_W)
)(
   input  logic [4:0]        code_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [DATA_W-1:0] res_o
);
   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("cmp_shift_unit: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   shu_size_e         size;
   shu_op_e           op;
   logic [DATA_W-1:0] lane_res [SHU_LANES];

   shu_decode u_dec (
      .code_i (code_i),
      .size_o (size),
      .op_o   (op)
   );

   for (genvar gi = 0; gi < SHU_LANES; gi++) begin : g_lane
      localparam int unsigned LW  = DATA_W >> (SHU_LANES - 1 - gi);
      localparam int unsigned LCW = $clog2(LW);
      shu_lane #(
         .DATA_W (DATA_W),
         .LANE_W (LW)
      ) u_lane (
         .x_i   (opnd_i[LW-1:0]),
         .cnt_i (cnt_i[LCW-1:0]),
         .op_i  (op),
         .res_o (lane_res[gi])
      );
   end

   assign res_o = lane_res[size];
endmodule

// File: rtl/shu_checker.sv
module shu_checker #(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned CNT_W = $clog2(DATA_W)
)(
   input logic [4:0]        code_i,
   input logic [DATA_W-1:0] opnd_i,
   input logic [CNT_W-1:0]  cnt_i,
   input logic [DATA_W-1:0] res_o
);
   int unsigned       w;
   int unsigned       k;
   logic [DATA_W-1:0] wmask;
   logic [DATA_W-1:0] sx_opnd;
   logic [DATA_W-1:0] sx_res;
   logic [1:0]        opc;

   always_comb begin
      if (!code_i[4])              w = DATA_W;
      else if (code_i[1:0] == 2'b11) w = DATA_W / 8;
      else if (code_i[1:0] == 2'b10) w = DATA_W / 4;
      else                          w = DATA_W / 2;
      k     = int'(cnt_i) & (w - 1);
      opc   = code_i[3:2];
      wmask = {DATA_W{1'b1}} >> (DATA_W - w);
      sx_opnd = opnd_i & wmask;
      sx_res  = res_o & wmask;
      if (opnd_i[w-1]) sx_opnd = sx_opnd | ~wmask;
      if (res_o[w-1])  sx_res  = sx_res  | ~wmask;
   end

   always_comb begin
      if (!$isunknown({code_i, opnd_i, cnt_i})) begin
         AST_SIGN_EXTENDED: assert (res_o == sx_res)
            else $error("upper bits do not replicate width sign"); // R8
         AST_ZERO_COUNT_KEEPS: assert (k != 0 || res_o == sx_opnd)
            else $error("zero count altered operand"); // R9
         AST_LSL_LOW_ZERO: assert (opc != 2'd0 || (res_o & ~({DATA_W{1'b1}} << k)) == '0)
            else $error("left shift left nonzero low bits"); // R2
         AST_ASR_KEEPS_SIGN: assert (opc != 2'd3 || res_o[w-1] == opnd_i[w-1])
            else $error("arithmetic right changed sign"); // R4
         AST_ROL_KEEPS_ONES: assert (opc != 2'd2 || $countones(res_o & wmask) == $countones(opnd_i & wmask))
            else $error("rotate lost bits"); // R5
      end
   end
endmodule

bind cmp_shift_unit shu_checker #(.DATA_W(DATA_W)) i_shu_checker (
   .code_i (code_i),
   .opnd_i (opnd_i),
   .cnt_i  (cnt_i),
   .res_o  (res_o)
);

// File: tb/test_cmp_shift_unit.sv
module test_cmp_shift_unit;
   localparam int CLK_PER  = 10;
   localparam int WD_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  code;
   logic [63:0] opnd;
   logic [5:0]  cnt;
   logic [63:0] res;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   cmp_shift_unit i_cmp_shift_unit (
      .code_i (code),
      .opnd_i (opnd),
      .cnt_i  (cnt),
      .res_o  (res)
   );

   function automatic int width_of(input logic [4:0] c);
      if (!c[4])             return 64;
      if (c[1:0] == 2'b11)   return 8;
      if (c[1:0] == 2'b10)   return 16;
      return 32;
   endfunction

   function automatic logic [63:0] model(input logic [4:0] c, input logic [63:0] x,
                                          input logic [5:0] n);
      int w = width_of(c);
      int s = int'(n) % w;
      logic [63:0] r = '0;
      for (int i = 0; i < w; i++) begin
         case (c[3:2])
            2'd0: r[i] = (i >= s) ? x[i-s] : 1'b0;
            2'd1: r[i] = (i + s < w) ? x[i+s] : 1'b0;
            2'd2: r[i] = x[(i - s + w) % w];
            default: r[i] = (i + s < w) ? x[i+s] : x[w-1];
         endcase
      end
      for (int i = w; i < 64; i++) r[i] = r[w-1];
      return r;
   endfunction

   task automatic drive(input logic [4:0] c, input logic [63:0] x, input logic [5:0] n);
      @(negedge clk);
      code = c; opnd = x; cnt = n;
      #1;
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s code=%b cnt=%0d act=%h exp=%h", tag, code, cnt, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_LIMIT && !done) begin
         n_fail++;
         $display("FAIL watchdog act=%0d exp<=%0d", cycles, WD_LIMIT);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] pats [6];
      logic [63:0] clean_r;
      string tag;
      pats[0] = 64'h0000_0000_0000_0000;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h0123_4567_89AB_CDEF;
      pats[3] = 64'hF0E1_D2C3_B4A5_9687;
      pats[4] = 64'h7FFF_8000_7F80_8001;
      pats[5] = 64'h8000_0000_0000_0001;
      code = '0; opnd = '0; cnt = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // R1: directed code points
      drive(5'b10100, 64'h0000_0000_8000_0010, 6'd4);
      check("R1 LSR word", res, 64'h0000_0000_0800_0001);
      drive(5'b11111, 64'h1234_5678_9ABC_DE90, 6'd2);
      check("R1 ASR byte", res, 64'hFFFF_FFFF_FFFF_FFE4);
      drive(5'b01000, 64'h8000_0000_0000_0001, 6'd1);
      check("R1 RL long", res, 64'h0000_0000_0000_0003);
      drive(5'b11010, 64'hFFFF_FFFF_FFFF_8001, 6'd4);
      check("R1 RL half", res, 64'h0000_0000_0000_0018);
      drive(5'b00000, 64'h0000_0000_0000_0001, 6'd63);
      check("R1 LSL long", res, 64'h8000_0000_0000_0000);

      // sweep every code, count and operand pattern
      for (int c = 0; c < 32; c++) begin
         for (int n = 0; n < 64; n++) begin
            for (int p = 0; p < 6; p++) begin
               int w = width_of(5'(c));
               drive(5'(c), pats[p], 6'(n));
               if (n % w == 0)      tag = "R9 zero count";
               else if (n >= w)     tag = "R6 count wrap";
               else case (c[3:2])
                  2'd0: tag = "R2 LSL";
                  2'd1: tag = "R3 LSR";
                  2'd2: tag = "R5 ROL";
                  default: tag = "R4 ASR";
               endcase
               check(tag, res, model(5'(c), pats[p], 6'(n)));
               check("R8 sign extension", res, model(5'(c), res, 6'd0));
            end
         end
      end

      // R7: upper operand bits ignored
      for (int c = 16; c < 32; c++) begin
         for (int n = 0; n < 8; n++) begin
            int w = width_of(5'(c));
            logic [63:0] low = pats[3] & ({64{1'b1}} >> (64 - w));
            drive(5'(c), low, 6'(n * 5));
            clean_r = res;
            drive(5'(c), low | ~({64{1'b1}} >> (64 - w)), 6'(n * 5));
            check("R7 upper bits ignored", res, clean_r);
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule